// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block generates the word-address stream for synchronous burst reads from a word-addressed array of 16,777,216 sixteen-bit words, so addresses are 24 bits wide. A burst begins on the clock edge where chip enable and the address strobe are both low. On that edge the block captures the start address and the burst mode. From the next cycle on it presents one array address per clock.

Three burst modes exist:
- An unbounded linear burst, which counts through the whole address space and rolls over from the top address to zero.
- An 8-word burst that wraps inside its aligned group.
- A 16-word burst that wraps inside its aligned group.

A wrapping burst ends by itself after its last word. Raising chip enable, applying reset or strobing a new address ends a burst at any cycle. A new strobe restarts the sequence at once from the new address.

A ready flag marks every cycle in which the array address is a valid burst word. A data-valid flag additionally requires that output enable was low. The array model, initial access latency and write-side control sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: On a rising clock edge with `ce_n`=0 and `adv_n`=0, `addr_in` and `mode_in` are captured. In the following cycle `arr_addr` equals the captured address and `ready`=1.
- R2: In linear mode (`mode_in`=2'b00, and also 2'b11), `arr_addr` increases by one on every clock while the burst runs. It rolls over from 24'hFFFFFF to 24'h000000, and the burst has no length limit.
- R3: In 8-word wrap mode (`mode_in`=2'b01), only `arr_addr[2:0]` increments, wrapping from 7 to 0, and bits [23:3] stay fixed. After exactly 8 words `ready` drops and `arr_addr` returns to 0.
- R4: In 16-word wrap mode (`mode_in`=2'b10), only `arr_addr[3:0]` increments, wrapping from 15 to 0, and bits [23:4] stay fixed. After exactly 16 words `ready` drops and `arr_addr` returns to 0.
- R5: A clock edge with `ce_n`=1 ends any burst. In the next cycle `ready`=0, `data_valid`=0 and `arr_addr`=0.
- R6: `rst` is synchronous and active high, and it takes priority over every other input. After an edge with `rst`=1, `ready`=0, `data_valid`=0 and `arr_addr`=0.
- R7: An address strobe during a running burst abandons that burst. The next cycle shows the new address under the new mode, and the wrap word count starts again.
- R8: `data_valid` is 1 in a cycle exactly when `ready` is 1 and `oe_n` was 0 at the preceding clock edge.
- R9: An address strobe while `ce_n`=1 is ignored: `ready` stays 0 and `arr_addr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr_in | input | 24 | Start word address |
| mode_in | input | 2 | Burst mode: 00 linear, 01 wrap 8, 10 wrap 16, 11 linear |
| arr_addr | output | 24 | Registered array word address |
| data_valid | output | 1 | Registered flag: burst word valid and output enabled |
| ready | output | 1 | Registered flag: burst word valid |

## Verification
The assertions check the following on every cycle:
- The capture of the start address and mode.
- The one-step linear advance.
- The fixed upper bits and the low-bit increment of both wrap modes.
- That no wrap burst outlives its length.
- The idle outputs after reset or a chip-enable release.
- The gating of data-valid by ready and the earlier output enable.

Only the bench scenarios can show particular sequences. These include the rollover from the top address to zero, the exact word-by-word order of a wrap that starts in mid-group, and that mode 11 behaves as linear. They also include a restart in mid-burst with a different mode, and that a strobe during chip-enable release leaves the block idle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    BM_LINEAR     = 2'b00,
    BM_WRAP_SHORT = 2'b01,
    BM_WRAP_LONG  = 2'b10,
    BM_LINEAR_ALT = 2'b11
  } burst_mode_e;
endpackage

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int SHORT_LOG = 3,
  parameter int LONG_LOG  = 4
) (
  input  logic [ADDR_W-1:0] cur,
  input  burst_mode_e       mode,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] SHORT_MASK = {{(ADDR_W-SHORT_LOG){1'b0}}, {SHORT_LOG{1'b1}}};
  localparam logic [ADDR_W-1:0] LONG_MASK  = {{(ADDR_W-LONG_LOG){1'b0}}, {LONG_LOG{1'b1}}};

  logic [ADDR_W-1:0] inc;
  assign inc = cur + ONE;

  always_comb begin
    case (mode)
      BM_WRAP_SHORT: nxt = (cur & ~SHORT_MASK) | (inc & SHORT_MASK);
      BM_WRAP_LONG:  nxt = (cur & ~LONG_MASK)  | (inc & LONG_MASK);
      default:       nxt = inc;
    endcase
  end
endmodule

// File: rtl/burst_word_counter.sv
module burst_word_counter
  import burst_seq_pkg::*;
#(
  parameter int SHORT_LOG = 3,
  parameter int LONG_LOG  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        step,
  input  burst_mode_e mode,
  output logic        last
);
  localparam int CNT_W = LONG_LOG;
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((1 << SHORT_LOG) - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'((1 << LONG_LOG) - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + CNT_W'(1);
  end

  always_comb begin
    case (mode)
      BM_WRAP_SHORT: last = (cnt_q == SHORT_LAST);
      BM_WRAP_LONG:  last = (cnt_q == LONG_LAST);
      default:       last = 1'b0;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int SHORT_LOG = 3,
  parameter int LONG_LOG  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [1:0]        mode_in,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              data_valid,
  output logic              ready
);
  logic              active_q, nxt_active, load, last, step;
  logic              dv_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  burst_mode_e       mode_q;

  assign load = !ce_n && !adv_n;
  assign step = active_q && !ce_n && !load;

  always_comb begin
    if (ce_n)                  nxt_active = 1'b0;
    else if (load)             nxt_active = 1'b1;
    else if (active_q && last) nxt_active = 1'b0;
    else                       nxt_active = active_q;
  end

  burst_addr_step #(
    .ADDR_W(ADDR_W), .SHORT_LOG(SHORT_LOG), .LONG_LOG(LONG_LOG)
  ) u_step (
    .cur(addr_q), .mode(mode_q), .nxt(addr_nxt)
  );

  burst_word_counter #(
    .SHORT_LOG(SHORT_LOG), .LONG_LOG(LONG_LOG)
  ) u_cnt (
    .clk(clk), .rst(rst), .clear(load), .step(step), .mode(mode_q), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      dv_q     <= 1'b0;
      addr_q   <= '0;
      mode_q   <= BM_LINEAR;
    end else begin
      active_q <= nxt_active;
      dv_q     <= nxt_active && !oe_n;
      if (ce_n) begin
        addr_q <= '0;
      end else if (load) begin
        addr_q <= addr_in;
        mode_q <= burst_mode_e'(mode_in);
      end else if (active_q) begin
        addr_q <= last ? '0 : addr_nxt;
      end
    end
  end

  assign arr_addr   = addr_q;
  assign ready      = active_q;
  assign data_valid = dv_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int SHORT_LOG = 3,
  parameter int LONG_LOG  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              adv_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [1:0]        mode_in,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              data_valid,
  input logic              ready,
  input logic [1:0]        mode_q
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] SM  = {{(ADDR_W-SHORT_LOG){1'b0}}, {SHORT_LOG{1'b1}}};
  localparam logic [ADDR_W-1:0] LM  = {{(ADDR_W-LONG_LOG){1'b0}}, {LONG_LOG{1'b1}}};
  localparam logic [5:0] SHORT_LEN = 6'(1 << SHORT_LOG);
  localparam logic [5:0] LONG_LEN  = 6'(1 << LONG_LOG);

  logic       run_ok;
  logic [5:0] run_q;
  logic       adv_cont;
  assign adv_cont = ready && !ce_n && adv_n && !rst;

  always_ff @(posedge clk) begin
    if (rst)                   run_q <= '0;
    else if (!ce_n && !adv_n)  run_q <= '0;
    else if (ready)            run_q <= (run_q == 6'd63) ? run_q : run_q + 6'd1;
    else                       run_q <= '0;
  end
  assign run_ok = (mode_q == BM_WRAP_SHORT) ? (run_q < SHORT_LEN) :
                  (mode_q == BM_WRAP_LONG)  ? (run_q < LONG_LEN)  : 1'b1;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !adv_n) |=> (ready && arr_addr == $past(addr_in) && mode_q == $past(mode_in))); // R1
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv_cont && (mode_q == BM_LINEAR || mode_q == BM_LINEAR_ALT)) |=>
    (ready && arr_addr == $past(arr_addr) + ONE)); // R2
  AST_WRAP_SHORT_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv_cont && mode_q == BM_WRAP_SHORT) |=>
    (!ready || ((arr_addr & ~SM) == ($past(arr_addr) & ~SM) &&
                (arr_addr & SM) == (($past(arr_addr) + ONE) & SM)))); // R3
  AST_WRAP_LONG_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv_cont && mode_q == BM_WRAP_LONG) |=>
    (!ready || ((arr_addr & ~LM) == ($past(arr_addr) & ~LM) &&
                (arr_addr & LM) == (($past(arr_addr) + ONE) & LM)))); // R4
  AST_WRAP_LENGTH: assert property (@(posedge clk) disable iff (rst)
    ready |-> run_ok); // R3 R4
  AST_CE_IDLE: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (!ready && !data_valid && arr_addr == '0)); // R5 R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!ready && !data_valid && arr_addr == '0)); // R6
  AST_DV_GATE: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> ready); // R8
  AST_DV_OE: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !adv_n) |=> (data_valid == $past(!oe_n))); // R8
endmodule

bind burst_addr_seq burst_addr_seq_chk #(
  .ADDR_W(ADDR_W), .SHORT_LOG(SHORT_LOG), .LONG_LOG(LONG_LOG)
) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
  .addr_in(addr_in), .mode_in(mode_in), .arr_addr(arr_addr),
  .data_valid(data_valid), .ready(ready), .mode_q(mode_q)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
  logic        clk = 1'b0;
  logic        rst, ce_n, adv_n, oe_n;
  logic [23:0] addr_in, arr_addr;
  logic [1:0]  mode_in;
  logic        data_valid, ready;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  burst_addr_seq dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
    .addr_in(addr_in), .mode_in(mode_in), .arr_addr(arr_addr),
    .data_valid(data_valid), .ready(ready)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start(input logic [23:0] a, input logic [1:0] m);
    ce_n = 0; adv_n = 0; addr_in = a; mode_in = m; tick(); adv_n = 1;
  endtask

  task automatic t_reset();
    rst = 1; ce_n = 1; adv_n = 1; oe_n = 1; addr_in = '0; mode_in = 2'b00;
    tick(); tick();
    chk("R6 ready after reset", {31'd0, ready}, 0);
    chk("R6 dv after reset", {31'd0, data_valid}, 0);
    chk("R6 addr after reset", {8'd0, arr_addr}, 0);
    rst = 0; tick();
  endtask

  task automatic t_linear();
    oe_n = 0;
    start(24'h123456, 2'b00);
    chk("R1 start addr", {8'd0, arr_addr}, 32'h123456);
    chk("R1 ready", {31'd0, ready}, 1);
    chk("R8 dv with oe low", {31'd0, data_valid}, 1);
    for (int k = 1; k < 20; k++) begin
      tick();
      chk("R2 linear step", {8'd0, arr_addr}, 32'h123456 + k);
    end
    chk("R2 still ready after 20", {31'd0, ready}, 1);
    start(24'hFFFFFE, 2'b00);
    chk("R2 near top", {8'd0, arr_addr}, 32'hFFFFFE);
    tick(); chk("R2 top", {8'd0, arr_addr}, 32'hFFFFFF);
    tick(); chk("R2 rollover", {8'd0, arr_addr}, 0);
    tick(); chk("R2 after rollover", {8'd0, arr_addr}, 1);
    start(24'h000010, 2'b11);
    tick(); tick();
    chk("R2 mode 11 linear", {8'd0, arr_addr}, 32'h12);
    ce_n = 1; tick();
  endtask

  task automatic t_wrap(input logic [1:0] m, input int len, input string tag);
    logic [23:0] base = 24'h00ABCD & ~24'(len - 1);
    int lo = 32'hD & (len - 1);
    start(24'h00ABCD, m);
    for (int k = 0; k < len; k++) begin
      chk({tag, " wrap word"}, {8'd0, arr_addr}, {8'd0, base | 24'((lo + k) % len)});
      chk({tag, " ready in burst"}, {31'd0, ready}, 1);
      tick();
    end
    chk({tag, " ends after length"}, {31'd0, ready}, 0);
    chk({tag, " idle addr"}, {8'd0, arr_addr}, 0);
    tick();
    chk({tag, " stays idle"}, {31'd0, ready}, 0);
  endtask

  task automatic t_ce();
    start(24'h000400, 2'b00);
    tick();
    ce_n = 1; tick();
    chk("R5 ready after ce high", {31'd0, ready}, 0);
    chk("R5 dv after ce high", {31'd0, data_valid}, 0);
    chk("R5 addr after ce high", {8'd0, arr_addr}, 0);
    adv_n = 0; addr_in = 24'h777777; tick(); adv_n = 1;
    chk("R9 strobe ignored ready", {31'd0, ready}, 0);
    chk("R9 strobe ignored addr", {8'd0, arr_addr}, 0);
  endtask

  task automatic t_restart();
    start(24'h000100, 2'b00);
    tick();
    chk("R7 pre-restart", {8'd0, arr_addr}, 32'h101);
    start(24'h002007, 2'b01);
    chk("R7 restart addr", {8'd0, arr_addr}, 32'h2007);
    for (int k = 1; k < 8; k++) begin
      tick();
      chk("R7 restart wrap", {8'd0, arr_addr}, 32'h2000 + (k - 1));
    end
    tick();
    chk("R7 restart wrap ends", {31'd0, ready}, 0);
    ce_n = 1; tick();
  endtask

  task automatic t_oe();
    oe_n = 0;
    start(24'h000020, 2'b00);
    oe_n = 1; tick();
    chk("R8 dv low with oe high", {31'd0, data_valid}, 0);
    chk("R8 ready with oe high", {31'd0, ready}, 1);
    oe_n = 0; tick();
    chk("R8 dv back", {31'd0, data_valid}, 1);
    oe_n = 1; start(24'h000030, 2'b00); oe_n = 0;
    chk("R8 dv low after load with oe high", {31'd0, data_valid}, 0);
    ce_n = 1; tick();
  endtask

  task automatic t_rst_mid();
    start(24'h000050, 2'b10);
    tick();
    rst = 1; adv_n = 0; tick(); rst = 0; adv_n = 1;
    chk("R6 reset beats strobe ready", {31'd0, ready}, 0);
    chk("R6 reset beats strobe addr", {8'd0, arr_addr}, 0);
    ce_n = 1; tick();
  endtask

  initial begin
    t_reset();
    t_linear();
    t_wrap(2'b01, 8, "R3");
    t_wrap(2'b10, 16, "R4");
    t_ce();
    t_restart();
    t_oe();
    t_rst_mid();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule